// File: doc/BRIEF.md
# UDP/DSCP Receive Queue Screener

This block sorts each received Ethernet frame into one of sixteen receive queues. Frame bytes enter on a byte-wide stream with valid/ready handshaking. The stream also carries start-of-frame and end-of-frame flags on the byte they belong to. While the frame passes, the block records the IPv4 traffic-class byte and the two bytes of the UDP port. It records each of these bytes only if the frame is long enough to contain it.

A small bank of screening rules is loaded through a plain write port. At the end of each frame, the rules are tried from the lowest index upward. The first rule that hits supplies the queue number. A rule hits only if it has at least one comparison enabled and every enabled comparison matches. If no rule hits, the frame goes to queue 0.

The result is a 4-bit queue number with a one-cycle valid pulse. The block never applies back-pressure: `in_ready` is always high, and every cycle with `in_valid` high inside a frame accepts one byte. Cycles with `in_valid` low are ignored, whatever the other stream pins carry.

Top module: `udp_dscp_screener`

## Requirements
- R1: A rule word is laid out as follows: bit 29 enables the port comparison, bit 28 enables the traffic-class comparison, bits 27:12 hold the 16-bit port, bits 11:4 hold the 8-bit traffic class, and bits 3:0 hold the target queue. Bits 31:30 are ignored.
- R2: The port compared is frame byte 36 (high half) followed by frame byte 37 (low half), where byte 0 is the start-of-frame byte.
- R3: The traffic class compared is frame byte 15.
- R4: A rule hits only when it has at least one comparison enabled and every enabled comparison equals its field. A rule with both enables clear never hits.
- R5: When several rules hit, the rule with the lowest index supplies the queue.
- R6: When no rule hits, the queue result is 0.
- R7: If a frame ends before byte 37, any enabled port comparison fails. If a frame ends before byte 15, any enabled traffic-class comparison fails. A one-byte frame therefore always yields queue 0.
- R8: `res_valid` is high for exactly one cycle, on the clock edge after the end-of-frame byte is accepted. At that edge `res_queue` shows the result. `res_queue` changes only at such an edge.
- R9: The captured fields are cleared at every start of frame, so a field seen in one frame never affects a shorter frame that follows.
- R10: A rule write accepted while a frame is in progress does not affect that frame. It applies from the next frame on.
- R11: A write whose index is not below NUM_RULES changes no rule.
- R12: `in_ready` is always high. Cycles with `in_valid` low accept no byte and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte present on the stream |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Marks byte 0 of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | 4 | Index of the rule to write |
| cfg_wdata | input | 32 | Rule word (layout in R1) |
| res_valid | output | 1 | One-cycle result strobe |
| res_queue | output | 4 | Selected queue |

## Verification
A wrong byte counter or a stale capture register shows up as a wrong `res_queue` on the very next result pulse. The effect appears when a frame's length falls just below or just above offsets 15, 16, 37 or 38. It also appears when a long frame is followed by a short one. A wrong rule-bank snapshot can only be seen on the result of a frame that had a rule write during it. A broken frame-tracking flag makes `res_valid` appear without an end-of-frame byte, or go missing when one is given. Either fault is visible one cycle after the final byte.

// File: rtl/screen_pkg.sv
package screen_pkg;
  localparam int MAX_RULES   = 16;
  localparam int QUEUE_W     = 4;
  localparam int RULE_W      = 32;
  localparam int TCLASS_OFS  = 15;
  localparam int PORT_HI_OFS = 36;
  localparam int PORT_LO_OFS = 37;
  localparam int POS_W       = $clog2(PORT_LO_OFS + 2);

  typedef struct packed {
    logic [1:0]         spare;
    logic               port_on;
    logic               tclass_on;
    logic [15:0]        port;
    logic [7:0]         tclass;
    logic [QUEUE_W-1:0] queue;
  } rule_t;

  typedef struct packed {
    logic [7:0] port_hi;
    logic [7:0] port_lo;
    logic [7:0] tclass;
    logic       hi_seen;
    logic       lo_seen;
    logic       tclass_seen;
  } fields_t;
endpackage

// File: rtl/screen_field_capture.sv
module screen_field_capture
  import screen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       sof,
  input  logic [7:0] data,
  output fields_t    fld_next
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, pos_cur;
  fields_t          fld_q, base;

  always_comb begin
    pos_cur  = sof ? '0 : pos_q;
    base     = (beat && sof) ? '0 : fld_q;
    fld_next = base;
    if (beat) begin
      if (pos_cur == POS_W'(TCLASS_OFS)) begin
        fld_next.tclass      = data;
        fld_next.tclass_seen = 1'b1;
      end
      if (pos_cur == POS_W'(PORT_HI_OFS)) begin
        fld_next.port_hi = data;
        fld_next.hi_seen = 1'b1;
      end
      if (pos_cur == POS_W'(PORT_LO_OFS)) begin
        fld_next.port_lo = data;
        fld_next.lo_seen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      fld_q <= '0;
    end else begin
      fld_q <= fld_next;
      if (beat) pos_q <= (pos_cur == POS_MAX) ? pos_cur : pos_cur + 1'b1;
    end
  end
endmodule

// File: rtl/screen_rule_match.sv
module screen_rule_match
  import screen_pkg::*;
(
  input  rule_t   rule,
  input  fields_t fld,
  output logic    hit
);
  logic port_ok, tclass_ok;

  always_comb begin
    port_ok   = fld.hi_seen && fld.lo_seen && ({fld.port_hi, fld.port_lo} == rule.port);
    tclass_ok = fld.tclass_seen && (fld.tclass == rule.tclass);
    hit = (rule.port_on || rule.tclass_on)
          && (!rule.port_on || port_ok)
          && (!rule.tclass_on || tclass_ok);
  end
endmodule

// File: rtl/screen_first_hit.sv
module screen_first_hit
  import screen_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]              hit,
  input  logic [N-1:0][QUEUE_W-1:0] queues,
  output logic [QUEUE_W-1:0]        queue
);
  always_comb begin
    queue = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) queue = queues[i];
    end
  end
endmodule

// File: rtl/udp_dscp_screener.sv
module udp_dscp_screener
  import screen_pkg::*;
#(
  parameter int NUM_RULES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  output logic        res_valid,
  output logic [3:0]  res_queue
);
  logic    in_frame;
  logic    beat;
  fields_t fld_next;
  rule_t   pending [NUM_RULES];
  rule_t   active  [NUM_RULES];
  logic [NUM_RULES-1:0]              hits;
  logic [NUM_RULES-1:0][QUEUE_W-1:0] queues;
  logic [QUEUE_W-1:0]                picked;

  assign in_ready = 1'b1;
  assign beat     = in_valid && (in_frame || in_sof);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_frame <= 1'b0;
    else if (beat) in_frame <= !in_eof;
  end

  screen_field_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .sof      (in_sof),
    .data     (in_data),
    .fld_next (fld_next)
  );

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    rule_t eval_rule;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[g] <= '0;
        active[g]  <= '0;
      end else begin
        if (cfg_we && (cfg_idx == 4'(g))) pending[g] <= rule_t'(cfg_wdata);
        if (!in_frame) active[g] <= pending[g];
      end
    end

    assign eval_rule = in_frame ? active[g] : pending[g];
    assign queues[g] = eval_rule.queue;

    screen_rule_match u_match (
      .rule (eval_rule),
      .fld  (fld_next),
      .hit  (hits[g])
    );
  end

  screen_first_hit #(.N(NUM_RULES)) u_pick (
    .hit    (hits),
    .queues (queues),
    .queue  (picked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_queue <= '0;
    end else begin
      res_valid <= beat && in_eof;
      if (beat && in_eof) res_queue <= picked;
    end
  end
endmodule

// File: rtl/screen_checker.sv
module screen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sof,
  input logic       in_eof,
  input logic       res_valid,
  input logic [3:0] res_queue
);
  assert_pulse_needs_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_eof));

  assert_quiet_after_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !res_valid);

  assert_queue_moves_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_queue != $past(res_queue)) |-> res_valid);

  assert_single_byte_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(in_sof)) |-> (res_queue == 4'd0));
endmodule

bind udp_dscp_screener screen_checker u_screen_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_eof    (in_eof),
  .res_valid (res_valid),
  .res_queue (res_queue)
);

// File: tb/udp_dscp_screener_test.sv
module udp_dscp_screener_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        res_valid;
  logic [3:0]  res_queue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] model_rules [4];

  always #2 clk = ~clk;

  udp_dscp_screener #(.NUM_RULES(4)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .res_valid(res_valid),
    .res_queue(res_queue)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_rule(input bit pe, input bit de, input logic [15:0] p,
                                          input logic [7:0] d, input logic [3:0] q);
    return {2'b11, pe, de, p, d, q};  // R1 layout; spare bits set to show they are ignored
  endfunction

  function automatic logic [7:0] byte_of(input int i, input logic [15:0] p, input logic [7:0] d);
    if (i == 15) return d;           // R3
    if (i == 36) return p[15:8];     // R2
    if (i == 37) return p[7:0];
    return 8'(i * 29 + 7);
  endfunction

  function automatic int model(input int len, input logic [15:0] p, input logic [7:0] d);
    for (int r = 0; r < 4; r++) begin
      logic [31:0] w;
      bit ok;
      w = model_rules[r];
      if (!w[29] && !w[28]) continue;             // R4
      ok = 1'b1;
      if (w[29]) ok = ok && (len >= 38) && (p == w[27:12]);  // R7
      if (w[28]) ok = ok && (len >= 16) && (d == w[11:4]);
      if (ok) return int'(w[3:0]);                // R5
    end
    return 0;                                     // R6
  endfunction

  task automatic write_rule(input int idx, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 4) model_rules[idx] = w;
  endtask

  task automatic send_frame(input int len, input logic [15:0] p, input logic [7:0] d,
                            input int gap, input int wr_at, input logic [31:0] wr_word,
                            input string tag);
    int exp;
    exp = model(len, p, d);
    for (int i = 0; i < len; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        cfg_we = 1'b0;
        in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'hA5;  // R12 junk
      end
      @(negedge clk);
      cfg_we = (i == wr_at);
      cfg_idx = 4'd0; cfg_wdata = wr_word;
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = byte_of(i, p, d);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    check(res_valid === 1'b1, {tag, " R8 valid"}, int'(res_valid), 1);
    check(res_queue === 4'(exp), {tag, " queue"}, int'(res_queue), exp);
    @(negedge clk);
    check(res_valid === 1'b0, {tag, " R8 single pulse"}, int'(res_valid), 0);
    if (wr_at >= 0 && wr_at < len) model_rules[0] = wr_word;
  endtask

  initial begin
    logic [15:0] ports [3];
    logic [7:0]  tcs [3];
    int          lens [6];
    ports = '{16'h1234, 16'h0035, 16'hFFFF};
    tcs   = '{8'hB8, 8'h28, 8'h00};
    lens  = '{10, 15, 16, 37, 38, 64};
    for (int r = 0; r < 4; r++) model_rules[r] = '0;

    repeat (3) @(negedge clk);
    check(res_valid === 1'b0, "reset valid", int'(res_valid), 0);
    check(res_queue === 4'd0, "reset queue", int'(res_queue), 0);
    check(in_ready === 1'b1, "R12 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R12 ready", int'(in_ready), 1);

    // No rules written: every frame goes to queue 0 (R6, R4)
    send_frame(64, 16'h1234, 8'hB8, 0, -1, 0, "R6 empty bank");

    // Configuration A: priority overlap and a never-hit rule (R4 R5)
    write_rule(0, mk_rule(1, 1, 16'h1234, 8'h28, 4'd9));
    write_rule(1, mk_rule(1, 0, 16'h1234, 8'h00, 4'd5));
    write_rule(2, mk_rule(0, 1, 16'h0000, 8'hB8, 4'd3));
    write_rule(3, mk_rule(0, 0, 16'h0035, 8'h00, 4'd7));
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 6; c++)
          send_frame(lens[c], ports[a], tcs[b], (c == 3) ? 2 : 0, -1, 0, "R2 R3 R5 R7 R9 sweep A");

    // Configuration B
    write_rule(0, mk_rule(0, 1, 16'h0000, 8'h00, 4'd1));
    write_rule(1, mk_rule(1, 0, 16'h0035, 8'h00, 4'd12));
    write_rule(2, mk_rule(1, 1, 16'hFFFF, 8'hB8, 4'd15));
    write_rule(3, mk_rule(1, 1, 16'h1234, 8'h28, 4'd2));
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 5; c >= 0; c--)
          send_frame(lens[c], ports[a], tcs[b], (a == 1) ? 1 : 0, -1, 0, "R4 R6 R7 R9 sweep B");

    // R9: long hitting frame then a short one
    send_frame(64, 16'h0035, 8'h11, 0, -1, 0, "R9 long");
    send_frame(20, 16'h0035, 8'h11, 0, -1, 0, "R9 short after long");

    // R7: one-byte frame
    send_frame(1, 16'h0035, 8'h00, 0, -1, 0, "R7 one byte");

    // R11: out-of-range index changes nothing
    write_rule(9, mk_rule(0, 1, 16'h0000, 8'h11, 4'd6));
    send_frame(40, 16'h4444, 8'h11, 0, -1, 0, "R11 ignored index");

    // R10: write to rule 0 during a frame; old bank for this frame, new for next
    send_frame(40, 16'h4444, 8'h11, 0, 20, mk_rule(0, 1, 16'h0000, 8'h11, 4'd8), "R10 during write");
    send_frame(40, 16'h4444, 8'h11, 0, -1, 0, "R10 next frame");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule